// File: doc/BRIEF.md
# Keypad Scanner and Key-Code Latch

This block drives a 20-key switch matrix of 4 rows and 5 columns by pulling one row low at a time. It samples the column lines at the end of each row slot and reduces every full sweep of the matrix to a single snapshot: no key, exactly one key (with its code), or several keys. It debounces by accepting a snapshot only once the same snapshot has been seen on 16 sweeps in a row. No processor involvement is needed.

An accepted single key is written into a code register that keeps its value after the key is let go. A new entry also raises a sticky data-available flag. The processor reads the code through a bus read port. The port drives the shared data bus only while it is selected, and the read clears the flag. A key that stays down produces one entry only, because a new code is registered only after the whole matrix has been seen stable with nothing pressed. Column inputs pass through a two-stage synchronizer, so each row slot must last at least three clocks.

Top module: `keypad_encoder`

## Requirements
- R1: Exactly one row output is low at any time. Each row stays low for ROW_CYCLES clocks, and the rows are visited in the order 0, 1, 2, 3, 0, ...
- R2: After reset, data_avail_o is 0, bus_drive_o is 0 and the stored code is 0.
- R3: A key is registered only after its sweep snapshot has been identical for 16 consecutive sweeps. A closure lasting fewer sweeps than that produces no entry.
- R4: The code of the key in row r (0..3) and column c (0..4) is r*5+c, so it ranges over 0..19. It appears in bus_data_o[4:0], and bus_data_o[7:5] reads 0.
- R5: The stored code does not change after the key is released. It changes only when a new entry is registered.
- R6: data_avail_o rises on the clock after an entry is registered. It then stays high until a read.
- R7: A clock with rd_en_i high clears data_avail_o on the next clock. The flag does not rise again until a new key press is registered.
- R8: A new entry is registered only after the whole matrix has been stably idle for 16 sweeps since the previous entry or since reset. A key held down therefore yields a single entry.
- R9: A sweep that sees two or more closed keys, in the same row or in different rows, never registers an entry and leaves the stored code unchanged.
- R10: bus_drive_o equals rd_en_i. While rd_en_i is low, bus_data_o is all zeros.
- R11: When an entry is registered on a clock in which rd_en_i is high, the entry wins. data_avail_o is high on the next clock and the new code is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_n_o | output | ROWS | Row drive, active low, one row at a time |
| col_n_i | input | COLS | Column sense, low when a key in the driven row is closed |
| rd_en_i | input | 1 | Bus read select for the key-code port |
| bus_data_o | output | DATA_W | Key code, zero-extended, valid while selected |
| bus_drive_o | output | 1 | Enable of the tristate bus driver |
| data_avail_o | output | 1 | Sticky flag: a new key code is waiting |

## Verification
Registering a new key and a processor read can fall in the same clock. The flag then has two opposite next values, and only the set must survive. The bench provokes this by holding rd_en_i high for the whole time that a key is being debounced, so the read is certain to be active on the registering clock. It judges the result by requiring that data_avail_o is seen high with the new code on the bus, and that the flag drops on the following clock because the read is still active.

// File: rtl/kp_pkg.sv
`timescale 1ns/1ps
package kp_pkg;
  typedef enum logic [1:0] {
    SNAP_NONE  = 2'd0,
    SNAP_ONE   = 2'd1,
    SNAP_MULTI = 2'd2
  } snap_e;

  // saturating add of key counts: 0, 1, or 2 meaning "two or more"
  function automatic logic [1:0] sat_add(input logic [1:0] a, input logic [1:0] b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > 3'd2) ? 2'd2 : s[1:0];
  endfunction
endpackage

// File: rtl/kp_row_scan.sv
`timescale 1ns/1ps
module kp_row_scan #(
  parameter int ROWS       = 4,
  parameter int ROW_CYCLES = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SW = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [RW-1:0]   row_idx_o,
  output logic [ROWS-1:0] row_n_o,
  output logic            sample_o,
  output logic            last_row_o
);
  logic [SW-1:0] slot_q, slot_d;
  logic [RW-1:0] row_q, row_d;
  logic          slot_end;

  always_comb begin
    slot_end = (slot_q == SW'(ROW_CYCLES - 1));
    slot_d   = slot_end ? '0 : slot_q + SW'(1);
    row_d    = row_q;
    if (slot_end) begin
      row_d = (row_q == RW'(ROWS - 1)) ? '0 : row_q + RW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      row_q  <= '0;
    end else begin
      slot_q <= slot_d;
      row_q  <= row_d;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_n_o[r] = (row_q != RW'(r));
  end

  assign row_idx_o  = row_q;
  assign sample_o   = slot_end;
  assign last_row_o = (row_q == RW'(ROWS - 1));
endmodule

// File: rtl/kp_matrix_snap.sv
`timescale 1ns/1ps
module kp_matrix_snap
  import kp_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 5,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = $clog2(ROWS * COLS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sample_i,
  input  logic            last_row_i,
  input  logic [RW-1:0]   row_idx_i,
  input  logic [COLS-1:0] col_hit_i,
  output logic            snap_valid_o,
  output snap_e           snap_class_o,
  output logic [CW-1:0]   snap_code_o
);
  logic [1:0]    acc_cnt_q, acc_cnt_d;
  logic [CW-1:0] acc_code_q, acc_code_d;
  logic [1:0]    row_cnt, tot_cnt;
  logic [CW-1:0] row_base, row_code, tot_code;
  logic          valid_q, valid_d;
  snap_e         class_q, class_d;
  logic [CW-1:0] code_q, code_d;

  always_comb begin
    row_cnt  = 2'd0;
    row_base = CW'(row_idx_i) * CW'(COLS);
    row_code = row_base;
    for (int c = 0; c < COLS; c++) begin
      if (col_hit_i[c]) begin
        row_cnt  = sat_add(row_cnt, 2'd1);
        row_code = row_base + CW'(c);
      end
    end
    tot_cnt  = sat_add(acc_cnt_q, row_cnt);
    tot_code = (row_cnt != 2'd0) ? row_code : acc_code_q;
  end

  always_comb begin
    acc_cnt_d  = acc_cnt_q;
    acc_code_d = acc_code_q;
    valid_d    = 1'b0;
    class_d    = class_q;
    code_d     = code_q;
    if (sample_i) begin
      if (last_row_i) begin
        acc_cnt_d  = 2'd0;
        acc_code_d = '0;
        valid_d    = 1'b1;
        code_d     = tot_code;
        case (tot_cnt)
          2'd0:    class_d = SNAP_NONE;
          2'd1:    class_d = SNAP_ONE;
          default: class_d = SNAP_MULTI;
        endcase
      end else begin
        acc_cnt_d  = tot_cnt;
        acc_code_d = tot_code;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt_q  <= 2'd0;
      acc_code_q <= '0;
      valid_q    <= 1'b0;
      class_q    <= SNAP_NONE;
      code_q     <= '0;
    end else begin
      acc_cnt_q  <= acc_cnt_d;
      acc_code_q <= acc_code_d;
      valid_q    <= valid_d;
      class_q    <= class_d;
      code_q     <= code_d;
    end
  end

  assign snap_valid_o = valid_q;
  assign snap_class_o = class_q;
  assign snap_code_o  = code_q;
endmodule

// File: rtl/kp_debounce.sv
`timescale 1ns/1ps
module kp_debounce
  import kp_pkg::*;
#(
  parameter int CW          = 5,
  parameter int DEB_SAMPLES = 16,
  localparam int DW = (DEB_SAMPLES > 1) ? $clog2(DEB_SAMPLES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snap_valid_i,
  input  snap_e         snap_class_i,
  input  logic [CW-1:0] snap_code_i,
  output logic          cap_o,
  output logic [CW-1:0] cap_code_o
);
  snap_e         prev_class_q, prev_class_d;
  logic [CW-1:0] prev_code_q, prev_code_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          cap_q, cap_d;
  logic          same, settle;

  always_comb begin
    same = (snap_class_i == prev_class_q) &&
           ((snap_class_i != SNAP_ONE) || (snap_code_i == prev_code_q));
    prev_class_d = prev_class_q;
    prev_code_d  = prev_code_q;
    cnt_d        = cnt_q;
    settle       = 1'b0;
    if (snap_valid_i) begin
      if (!same) begin
        prev_class_d = snap_class_i;
        prev_code_d  = snap_code_i;
        cnt_d        = '0;
      end else if (cnt_q != DW'(DEB_SAMPLES - 1)) begin
        cnt_d  = cnt_q + DW'(1);
        settle = (cnt_d == DW'(DEB_SAMPLES - 1));
      end
    end
    armed_d = armed_q;
    cap_d   = 1'b0;
    if (settle) begin
      if (prev_class_q == SNAP_NONE) begin
        armed_d = 1'b1;
      end else if (prev_class_q == SNAP_ONE && armed_q) begin
        armed_d = 1'b0;
        cap_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_class_q <= SNAP_MULTI;
      prev_code_q  <= '0;
      cnt_q        <= '0;
      armed_q      <= 1'b0;
      cap_q        <= 1'b0;
    end else begin
      prev_class_q <= prev_class_d;
      prev_code_q  <= prev_code_d;
      cnt_q        <= cnt_d;
      armed_q      <= armed_d;
      cap_q        <= cap_d;
    end
  end

  assign cap_o      = cap_q;
  assign cap_code_o = prev_code_q;
endmodule

// File: rtl/keypad_encoder.sv
`timescale 1ns/1ps
module keypad_encoder
  import kp_pkg::*;
#(
  parameter int ROWS        = 4,
  parameter int COLS        = 5,
  parameter int ROW_CYCLES  = 4,
  parameter int DEB_SAMPLES = 16,
  parameter int DATA_W      = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = $clog2(ROWS * COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ROWS-1:0]   row_n_o,
  input  logic [COLS-1:0]   col_n_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_drive_o,
  output logic              data_avail_o
);
  logic [1:0]      rst_sync_q;
  logic            srst_n;
  logic [COLS-1:0] col_meta_q, col_hit_q;
  logic [RW-1:0]   row_idx;
  logic            sample, last_row;
  logic            snap_valid;
  snap_e           snap_class;
  logic [CW-1:0]   snap_code;
  logic            cap_pulse;
  logic [CW-1:0]   cap_code;
  logic [CW-1:0]   code_q, code_d;
  logic            flag_q, flag_d;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  // column synchronizer, converted to active-high hits
  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      col_meta_q <= '0;
      col_hit_q  <= '0;
    end else begin
      col_meta_q <= ~col_n_i;
      col_hit_q  <= col_meta_q;
    end
  end

  kp_row_scan #(.ROWS(ROWS), .ROW_CYCLES(ROW_CYCLES)) u_scan (
    .clk_i(clk_i), .rst_ni(srst_n), .row_idx_o(row_idx), .row_n_o(row_n_o),
    .sample_o(sample), .last_row_o(last_row)
  );

  kp_matrix_snap #(.ROWS(ROWS), .COLS(COLS)) u_snap (
    .clk_i(clk_i), .rst_ni(srst_n), .sample_i(sample), .last_row_i(last_row),
    .row_idx_i(row_idx), .col_hit_i(col_hit_q), .snap_valid_o(snap_valid),
    .snap_class_o(snap_class), .snap_code_o(snap_code)
  );

  kp_debounce #(.CW(CW), .DEB_SAMPLES(DEB_SAMPLES)) u_deb (
    .clk_i(clk_i), .rst_ni(srst_n), .snap_valid_i(snap_valid),
    .snap_class_i(snap_class), .snap_code_i(snap_code),
    .cap_o(cap_pulse), .cap_code_o(cap_code)
  );

  // code latch and sticky flag; a new entry outranks a concurrent read
  always_comb begin
    code_d = cap_pulse ? cap_code : code_q;
    flag_d = flag_q;
    if (cap_pulse)    flag_d = 1'b1;
    else if (rd_en_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      code_q <= '0;
      flag_q <= 1'b0;
    end else begin
      code_q <= code_d;
      flag_q <= flag_d;
    end
  end

  assign data_avail_o = flag_q;
  assign bus_drive_o  = rd_en_i;
  assign bus_data_o   = rd_en_i ? DATA_W'(code_q) : '0;
endmodule

// File: rtl/kp_encoder_chk.sv
`timescale 1ns/1ps
module kp_encoder_chk #(
  parameter int ROWS   = 4,
  parameter int COLS   = 5,
  parameter int DATA_W = 8,
  parameter int CW     = 5
) (
  input logic              clk_i,
  input logic              srst_n,
  input logic [ROWS-1:0]   row_n_o,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_drive_o,
  input logic              data_avail_o,
  input logic              cap_pulse,
  input logic [CW-1:0]     code_q
);
  assert_row_onehot_R1: assert property (@(posedge clk_i) disable iff (!srst_n)
    $countones(~row_n_o) == 1);

  assert_code_range_R4: assert property (@(posedge clk_i) disable iff (!srst_n)
    rd_en_i |-> (bus_data_o < DATA_W'(ROWS * COLS)));

  assert_code_hold_R5: assert property (@(posedge clk_i) disable iff (!srst_n)
    !data_avail_o |-> $stable(code_q));

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!srst_n)
    (data_avail_o && !rd_en_i) |=> data_avail_o);

  assert_flag_source_R6: assert property (@(posedge clk_i) disable iff (!srst_n)
    $rose(data_avail_o) |-> $past(cap_pulse));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!srst_n)
    (rd_en_i && !cap_pulse) |=> !data_avail_o);

  assert_bus_idle_R10: assert property (@(posedge clk_i) disable iff (!srst_n)
    !rd_en_i |-> (!bus_drive_o && bus_data_o == '0));

  assert_bus_drive_R10: assert property (@(posedge clk_i) disable iff (!srst_n)
    rd_en_i |-> bus_drive_o);

  assert_entry_wins_R11: assert property (@(posedge clk_i) disable iff (!srst_n)
    cap_pulse |=> data_avail_o);
endmodule

bind keypad_encoder kp_encoder_chk #(
  .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .CW(CW)
) u_chk (
  .clk_i(clk_i), .srst_n(srst_n), .row_n_o(row_n_o), .rd_en_i(rd_en_i),
  .bus_data_o(bus_data_o), .bus_drive_o(bus_drive_o),
  .data_avail_o(data_avail_o), .cap_pulse(cap_pulse), .code_q(code_q)
);

// File: tb/keypad_encoder_tb.sv
`timescale 1ns/1ps
module keypad_encoder_tb;
  localparam int ROWS = 4, COLS = 5, RC = 4, SWEEP = ROWS * RC;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ROWS-1:0]   row_n;
  logic [COLS-1:0]   col_n;
  logic              rd_en;
  logic [7:0]        bus_data;
  logic              bus_drive;
  logic              avail;
  logic [ROWS*COLS-1:0] keys;
  int n_vec = 0, n_bad = 0;
  logic [4:0] last_code;

  always #4 clk = ~clk;

  keypad_encoder #(.ROWS(ROWS), .COLS(COLS), .ROW_CYCLES(RC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .row_n_o(row_n), .col_n_i(col_n),
    .rd_en_i(rd_en), .bus_data_o(bus_data), .bus_drive_o(bus_drive),
    .data_avail_o(avail)
  );

  // switch matrix model: a closed key pulls its column low when its row is driven
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (!row_n[r] && keys[r*COLS+c]) col_n[c] = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_code(output logic [7:0] d);
    rd_en = 1'b1;
    #1 d = bus_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_avail(input int max_cyc, output bit seen);
    seen = 0;
    for (int i = 0; i < max_cyc && !seen; i++) begin
      @(negedge clk);
      if (avail) seen = 1;
    end
  endtask

  task automatic t_reset;
    check(avail == 1'b0, "R2 flag", avail, 0);
    check(bus_drive == 1'b0, "R2 drive", bus_drive, 0);
    begin
      logic [7:0] d;
      read_code(d);
      check(d == 8'd0, "R2 code", d, 0);
    end
  endtask

  task automatic t_rows;
    int prev = -1, run = 0, cur;
    bit first = 1;
    for (int i = 0; i < 5 * SWEEP; i++) begin
      @(negedge clk);
      cur = -1;
      for (int r = 0; r < ROWS; r++) if (!row_n[r]) cur = r;
      if ($countones(~row_n) != 1) check(0, "R1 onehot", $countones(~row_n), 1);
      if (cur == prev) run++;
      else begin
        if (prev >= 0) begin
          check(cur == (prev + 1) % ROWS, "R1 order", cur, (prev + 1) % ROWS);
          if (!first) check(run == RC, "R1 dwell", run, RC);
          first = 0;
        end
        prev = cur;
        run = 1;
      end
    end
  endtask

  // press one key, require no entry before 14 sweeps and an entry by 40
  task automatic t_entry(input int key);
    bit seen;
    logic [7:0] d;
    keys = '0;
    keys[key] = 1'b1;
    cycles(14 * SWEEP);
    check(avail == 1'b0, "R3 early", avail, 0);
    wait_avail(26 * SWEEP, seen);
    check(seen, "R6 set", seen, 1);
    cycles(30);
    check(avail == 1'b1, "R6 sticky", avail, 1);
    read_code(d);
    check(d == 8'(key), "R4 code", d, key);
    check(avail == 1'b0, "R7 clear", avail, 0);
    keys = '0;
    cycles(20 * SWEEP);
    check(avail == 1'b0, "R7 no reset", avail, 0);
    read_code(d);
    check(d == 8'(key), "R5 hold", d, key);
    last_code = 5'(key);
  endtask

  task automatic t_short;
    keys = '0;
    keys[8] = 1'b1;
    cycles(10 * SWEEP);
    keys = '0;
    cycles(20 * SWEEP);
    check(avail == 1'b0, "R3 short press", avail, 0);
  endtask

  task automatic t_held;
    bit seen;
    logic [7:0] d;
    keys = '0;
    keys[11] = 1'b1;
    wait_avail(40 * SWEEP, seen);
    check(seen, "R8 first entry", seen, 1);
    read_code(d);
    check(d == 8'd11, "R8 code", d, 11);
    cycles(40 * SWEEP);
    check(avail == 1'b0, "R8 held once", avail, 0);
    keys = '0;
    cycles(20 * SWEEP);
    keys[12] = 1'b1;
    wait_avail(40 * SWEEP, seen);
    check(seen, "R8 re-armed", seen, 1);
    read_code(d);
    check(d == 8'd12, "R8 second code", d, 12);
    keys = '0;
    cycles(20 * SWEEP);
    last_code = 5'd12;
  endtask

  task automatic t_multi(input int k1, input int k2, input string tag);
    logic [7:0] d;
    keys = '0;
    keys[k1] = 1'b1;
    keys[k2] = 1'b1;
    cycles(40 * SWEEP);
    check(avail == 1'b0, tag, avail, 0);
    read_code(d);
    check(d == 8'(last_code), "R9 code kept", d, last_code);
    keys = '0;
    cycles(20 * SWEEP);
  endtask

  task automatic t_bus_idle;
    rd_en = 1'b0;
    #1;
    check(bus_drive == 1'b0, "R10 no drive", bus_drive, 0);
    check(bus_data == 8'd0, "R10 data quiet", bus_data, 0);
    rd_en = 1'b1;
    #1;
    check(bus_drive == 1'b1, "R10 drive", bus_drive, 1);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_collide;
    bit seen;
    rd_en = 1'b1;
    keys = '0;
    keys[17] = 1'b1;
    wait_avail(40 * SWEEP, seen);
    check(seen, "R11 entry beats read", seen, 1);
    check(bus_data == 8'd17, "R11 code", bus_data, 17);
    @(negedge clk);
    check(avail == 1'b0, "R11 then cleared", avail, 0);
    rd_en = 1'b0;
    keys = '0;
    cycles(20 * SWEEP);
    last_code = 5'd17;
  endtask

  initial begin
    #1_400_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    keys = '0;
    rd_en = 1'b0;
    last_code = '0;
    rst_n = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_rows();
    cycles(20 * SWEEP);
    t_short();
    t_entry(0);
    t_entry(19);
    t_entry(7);
    t_entry(13);
    t_held();
    t_multi(3, 16, "R9 two rows");
    t_multi(5, 6, "R9 same row");
    t_bus_idle();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule